// File: doc/BRIEF.md
# Boot Firmware Top-Swap Control Register

This block is a 32-bit control and status register that steers fetches from boot firmware. It holds three fields. The first is a read-only boot block size, loaded from a soft strap. The second is a writable boot destination, with LPC or SPI loaded from a pin strap. The third is a top-swap enable kept in the always-powered RTC well. A write-once lock bit sits alongside them. When top swap is on, firmware-range addresses have one bit inverted, so that fetches land in a backup copy of the boot block. Which bit is inverted follows from the size field and the destination.

The block has two synchronous, active-low resets. The RTC-well reset reloads every field. The platform reset reloads the size, the destination and the lock, but keeps the swap bit. The top-swap pin strap is captured at either reset. While that captured value is high, software cannot clear the swap bit.

The lock is a two-state machine. In state `LK_OPEN`, writes update the destination and swap fields. The transition `SEAL` is taken on any write with bit 0 set, and it moves the machine to `LK_SEALED`. In `LK_SEALED`, all writes are ignored. The transition `UNSEAL` is taken only through either reset, and it returns the machine to `LK_OPEN`. The address remap is purely combinational from the current register contents.

Top module: `fw_swap_ctrl`

## Requirements
- R1: Bits 30:29 hold the boot block size, loaded from `strap_blk_size` on either reset and unaffected by writes. The codes are 00 = 64KB, 01 = 128KB, 10 = 256KB and 11 = reserved.
- R2: Bits 11:10 hold the destination, loaded from `strap_dest` on either reset and writable while unlocked. Code 00 is LPC and code 11 is SPI. `route_spi` is high only for code 11.
- R3: With destination SPI, swap set, `fw_range` high and `feat_space` low, `addr_out` equals `addr_in` with bit 16, 17 or 18 inverted for size 00, 01 or 10 respectively.
- R4: With destination LPC or a reserved code, only bit 16 is ever inverted, whatever the size field holds.
- R5: With size code 11, no address bit is inverted.
- R6: `addr_out` equals `addr_in` when `feat_space` is high, when `fw_range` is low, or when the swap bit is clear.
- R7: The RTC-well reset loads the swap bit (bit 1) from `strap_swap_pin`. While the pin value captured at the last reset is high, the swap bit reads 1 and writes cannot clear it.
- R8: Platform reset leaves the swap bit unchanged, unless the pin strap is high, in which case it sets the bit.
- R9: The lock (bit 0) resets to 0 and is set by any write with bit 0 high. Once set, it stays set until a reset, and writes no longer change bits 11:10, bit 1 or bit 0.
- R10: Platform reset clears the lock and reloads the destination and size fields from their straps.
- R11: Bit 31, bits 28:12 and bits 9:2 read as 0 whatever is written to them.
- R12: Destination codes 01 and 10 raise `dest_rsvd` and keep `route_spi` low, so cycles go to LPC.
- R13: A write accepted at a clock edge is visible on `reg_rdata`, `addr_out`, `route_spi` and `dest_rsvd` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Synchronous active-low RTC-well reset |
| plat_rst_n | input | 1 | Synchronous active-low platform reset |
| strap_blk_size | input | 2 | Boot block size soft strap |
| strap_dest | input | 2 | Boot destination pin strap |
| strap_swap_pin | input | 1 | Top-swap pin strap |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| addr_in | input | AW | Fetch address before remap |
| fw_range | input | 1 | Address falls in the firmware range |
| feat_space | input | 1 | Address targets the feature space |
| addr_out | output | AW | Fetch address after remap |
| route_spi | output | 1 | Firmware cycles go to SPI |
| dest_rsvd | output | 1 | Destination field holds a reserved code |

## Verification
The assertions assume that both resets are synchronous and are held low over at least one rising edge before first use. They also assume that the straps are stable while a reset is being applied. The bench changes straps only at falling edges, and only while a reset is held. It drives `fw_range` and `feat_space` as plain levels, which may be in any combination, including both high at once; that is how the check that the feature space is never altered gets exercised. Write strobes last a single cycle and never overlap a reset, so the lock and freeze properties see clean write cycles.

// File: rtl/fw_swap_pkg.sv
package fw_swap_pkg;

    localparam int REG_W     = 32;
    localparam int SIZE_LSB  = 29;
    localparam int DEST_LSB  = 10;
    localparam int SWAP_POS  = 1;
    localparam int LOCK_POS  = 0;
    localparam logic [REG_W-1:0] RSVD_MASK = 32'h9FFF_F3FC;

    typedef enum logic [1:0] {
        DST_LPC  = 2'b00,
        DST_RSV1 = 2'b01,
        DST_RSV2 = 2'b10,
        DST_SPI  = 2'b11
    } dest_e;

    typedef enum logic [1:0] {
        SZ_64K  = 2'b00,
        SZ_128K = 2'b01,
        SZ_256K = 2'b10,
        SZ_RSV  = 2'b11
    } size_e;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/fw_swap_lock_fsm.sv
module fw_swap_lock_fsm
    import fw_swap_pkg::*;
(
    input  logic clk,
    input  logic rtc_rst_n,
    input  logic plat_rst_n,
    input  logic wr_en,
    input  logic wr_lock,
    output logic locked,
    output logic wr_open
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rtc_rst_n || !plat_rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_en && wr_lock) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        locked  = 1'b0;
        wr_open = 1'b0;
        unique case (state_q)
            LK_OPEN:   wr_open = wr_en;
            LK_SEALED: locked  = 1'b1;
            default:   wr_open = 1'b0;
        endcase
    end

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        (state_q == LK_SEALED) |=> (state_q == LK_SEALED));

    // R9
    lock_set_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        (wr_en && wr_lock) |=> locked);

endmodule

// File: rtl/fw_swap_fields.sv
module fw_swap_fields
    import fw_swap_pkg::*;
(
    input  logic       clk,
    input  logic       rtc_rst_n,
    input  logic       plat_rst_n,
    input  logic [1:0] strap_size,
    input  logic [1:0] strap_dest,
    input  logic       strap_pin,
    input  logic       wr_open,
    input  logic [1:0] wr_dest,
    input  logic       wr_swap,
    output size_e      size_q,
    output dest_e      dest_q,
    output logic       swap_q,
    output logic       pin_q
);

    always_ff @(posedge clk) begin
        if (!rtc_rst_n) begin
            size_q <= size_e'(strap_size);
            dest_q <= dest_e'(strap_dest);
            pin_q  <= strap_pin;
            swap_q <= strap_pin;
        end else if (!plat_rst_n) begin
            size_q <= size_e'(strap_size);
            dest_q <= dest_e'(strap_dest);
            pin_q  <= strap_pin;
            swap_q <= swap_q | strap_pin;
        end else if (wr_open) begin
            dest_q <= dest_e'(wr_dest);
            swap_q <= wr_swap | pin_q;
        end
    end

    // R7
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        pin_q |-> swap_q);

    // R8
    swap_keep_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        (!plat_rst_n && !strap_pin) |=> $stable(swap_q));

    // R1
    size_ro_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        wr_open |=> $stable(size_q));

endmodule

// File: rtl/fw_swap_remap.sv
module fw_swap_remap
    import fw_swap_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BASE_BIT  = 16,
    parameter int NUM_SIZES = 3
) (
    input  size_e           size_q,
    input  dest_e           dest_q,
    input  logic            swap_q,
    input  logic            fw_range,
    input  logic            feat_space,
    input  logic [AW-1:0]   addr_in,
    output logic [AW-1:0]   addr_out,
    output logic [AW-1:0]   flip_mask
);

    localparam int TOP_BIT = BASE_BIT + NUM_SIZES - 1;

    size_e           eff_size;
    logic [AW-1:0]   cand [NUM_SIZES];
    logic            active;

    always_comb begin
        eff_size = (dest_q == DST_SPI) ? size_q : SZ_64K;
    end

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_cand
        always_comb begin
            cand[g] = '0;
            if (eff_size == size_e'(g)) cand[g][BASE_BIT+g] = 1'b1;
        end
    end

    always_comb begin
        active    = swap_q && fw_range && !feat_space;
        flip_mask = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            flip_mask = flip_mask | cand[i];
        end
        if (!active) flip_mask = '0;
        addr_out = addr_in ^ flip_mask;
    end

    if (TOP_BIT >= AW) begin : g_bad_width
        initial $error("remap bit beyond address width");
    end

endmodule

// File: rtl/fw_swap_ctrl.sv
module fw_swap_ctrl
    import fw_swap_pkg::*;
#(
    parameter int AW       = 32,
    parameter int BASE_BIT = 16
) (
    input  logic             clk,
    input  logic             rtc_rst_n,
    input  logic             plat_rst_n,
    input  logic [1:0]       strap_blk_size,
    input  logic [1:0]       strap_dest,
    input  logic             strap_swap_pin,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [AW-1:0]    addr_in,
    input  logic             fw_range,
    input  logic             feat_space,
    output logic [AW-1:0]    addr_out,
    output logic             route_spi,
    output logic             dest_rsvd
);

    logic          locked;
    logic          wr_open;
    size_e         size_q;
    dest_e         dest_q;
    logic          swap_q;
    logic          pin_q;
    logic [AW-1:0] flip_mask;
    logic          unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:12], reg_wdata[9:2]};

    fw_swap_lock_fsm u_lock (
        .clk        (clk),
        .rtc_rst_n  (rtc_rst_n),
        .plat_rst_n (plat_rst_n),
        .wr_en      (reg_wr),
        .wr_lock    (reg_wdata[LOCK_POS]),
        .locked     (locked),
        .wr_open    (wr_open)
    );

    fw_swap_fields u_fields (
        .clk        (clk),
        .rtc_rst_n  (rtc_rst_n),
        .plat_rst_n (plat_rst_n),
        .strap_size (strap_blk_size),
        .strap_dest (strap_dest),
        .strap_pin  (strap_swap_pin),
        .wr_open    (wr_open),
        .wr_dest    (reg_wdata[DEST_LSB+1:DEST_LSB]),
        .wr_swap    (reg_wdata[SWAP_POS]),
        .size_q     (size_q),
        .dest_q     (dest_q),
        .swap_q     (swap_q),
        .pin_q      (pin_q)
    );

    fw_swap_remap #(
        .AW       (AW),
        .BASE_BIT (BASE_BIT),
        .NUM_SIZES(3)
    ) u_remap (
        .size_q     (size_q),
        .dest_q     (dest_q),
        .swap_q     (swap_q),
        .fw_range   (fw_range),
        .feat_space (feat_space),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .flip_mask  (flip_mask)
    );

    always_comb begin
        reg_rdata                         = '0;
        reg_rdata[SIZE_LSB+1:SIZE_LSB]    = size_q;
        reg_rdata[DEST_LSB+1:DEST_LSB]    = dest_q;
        reg_rdata[SWAP_POS]               = swap_q;
        reg_rdata[LOCK_POS]               = locked;
        route_spi = (dest_q == DST_SPI);
        dest_rsvd = (dest_q == DST_RSV1) || (dest_q == DST_RSV2);
    end

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        (reg_rdata & RSVD_MASK) == '0);

    // R6
    feat_pass_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        (feat_space || !fw_range || !reg_rdata[SWAP_POS]) |-> (addr_out == addr_in));

    // R3
    flip_one_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        $countones(addr_out ^ addr_in) <= 1);

    // R4
    lpc_bit_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        !route_spi |-> ((addr_out ^ addr_in) & ~(AW'(1) << BASE_BIT)) == '0);

    // R5
    rsvd_size_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        (route_spi && reg_rdata[SIZE_LSB+1:SIZE_LSB] == 2'b11) |-> (addr_out == addr_in));

    // R12
    rsvd_dest_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        dest_rsvd |-> !route_spi);

    // R9
    sealed_freeze_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n || !plat_rst_n)
        (locked && reg_wr) |=> ($stable(reg_rdata[DEST_LSB+1:DEST_LSB]) && $stable(reg_rdata[SWAP_POS])));

endmodule

// File: tb/fw_swap_ctrl_test.sv
`timescale 1ns/1ps
module fw_swap_ctrl_test;

    logic        clk = 1'b0;
    logic        rtc_rst_n = 1'b0;
    logic        plat_rst_n = 1'b1;
    logic [1:0]  strap_blk_size = 2'b00;
    logic [1:0]  strap_dest = 2'b00;
    logic        strap_swap_pin = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] addr_in = '0;
    logic        fw_range = 1'b0;
    logic        feat_space = 1'b0;
    logic [31:0] addr_out;
    logic        route_spi;
    logic        dest_rsvd;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fw_swap_ctrl uut (
        .clk(clk), .rtc_rst_n(rtc_rst_n), .plat_rst_n(plat_rst_n),
        .strap_blk_size(strap_blk_size), .strap_dest(strap_dest),
        .strap_swap_pin(strap_swap_pin), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .addr_in(addr_in), .fw_range(fw_range),
        .feat_space(feat_space), .addr_out(addr_out), .route_spi(route_spi),
        .dest_rsvd(dest_rsvd)
    );

    // {size[70:69], dest[68:67], pin[66], fw[65], feat[64], addr[63:32], expected[31:0]}
    localparam int NV = 11;
    localparam logic [70:0] VEC [NV] = '{
        {2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FE_0000}, // R3 64KB
        {2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FD_0000}, // R3 128KB
        {2'b10, 2'b11, 1'b1, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FB_0000}, // R3 256KB
        {2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FF_0000}, // R5
        {2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FE_0000}, // R4
        {2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FE_0000}, // R4
        {2'b10, 2'b11, 1'b1, 1'b1, 1'b1, 32'h00FF_0000, 32'h00FF_0000}, // R6 feature
        {2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 32'h00FF_0000, 32'h00FF_0000}, // R6 range
        {2'b10, 2'b11, 1'b0, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FF_0000}, // R6 swap off
        {2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 32'h00FF_0000, 32'h00FE_0000}, // R12
        {2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 32'h1234_ABCD, 32'h1235_ABCD}  // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rtc_reset(input logic [1:0] sz, input logic [1:0] ds, input logic pn);
        @(negedge clk);
        strap_blk_size = sz; strap_dest = ds; strap_swap_pin = pn;
        rtc_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rtc_rst_n = 1'b1;
        #1;
    endtask

    task automatic plat_reset(input logic [1:0] sz, input logic [1:0] ds, input logic pn);
        @(negedge clk);
        strap_blk_size = sz; strap_dest = ds; strap_swap_pin = pn;
        plat_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        plat_rst_n = 1'b1;
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // table walk: remap cases (R3 R4 R5 R6 R12)
        for (int i = 0; i < NV; i++) begin
            rtc_reset(VEC[i][70:69], VEC[i][68:67], VEC[i][66]);
            fw_range = VEC[i][65]; feat_space = VEC[i][64]; addr_in = VEC[i][63:32];
            #1;
            chk($sformatf("R3/R4/R5/R6 vec%0d", i), addr_out, VEC[i][31:0]);
        end

        // R1 R2 R11: reset readback
        rtc_reset(2'b10, 2'b11, 1'b0);
        chk("R1 R2 reset value", reg_rdata, 32'h4000_0C00);
        chk("R2 route_spi", {31'd0, route_spi}, 32'd1);

        rtc_reset(2'b01, 2'b00, 1'b0);
        chk("R1 reset value LPC", reg_rdata, 32'h2000_0000);
        chk("R2 route_spi low", {31'd0, route_spi}, 32'd0);

        // R11 R1 R2 R13: write all ones except lock
        fw_range = 1'b1; feat_space = 1'b0; addr_in = 32'h00FF_0000;
        wr(32'hFFFF_FFFE);
        chk("R11 R1 write readback", reg_rdata, 32'h2000_0C02);
        chk("R13 remap next cycle", addr_out, 32'h00FD_0000);
        chk("R2 route_spi after write", {31'd0, route_spi}, 32'd1);

        // R12: reserved destination
        wr(32'h0000_0400);
        chk("R12 readback", reg_rdata, 32'h2000_0400);
        chk("R12 dest_rsvd", {30'd0, dest_rsvd, route_spi}, 32'd2);

        // R9: lock with same write
        wr(32'h0000_0C03);
        chk("R9 lock set", reg_rdata, 32'h2000_0C03);
        wr(32'h0000_0000);
        chk("R9 locked write ignored", reg_rdata, 32'h2000_0C03);
        chk("R9 remap unchanged", addr_out, 32'h00FD_0000);

        // R10 R8: platform reset
        plat_reset(2'b01, 2'b00, 1'b0);
        chk("R10 R8 plat reset", reg_rdata, 32'h2000_0002);
        chk("R8 remap after plat reset", addr_out, 32'h00FE_0000);
        wr(32'h0000_0000);
        chk("R10 unlocked after plat reset", reg_rdata, 32'h2000_0000);

        // R8: pin strap at platform reset sets swap
        plat_reset(2'b01, 2'b11, 1'b1);
        chk("R8 pin at plat reset", reg_rdata, 32'h2000_0C02);

        // R7: pin strap forbids clearing swap
        rtc_reset(2'b01, 2'b00, 1'b1);
        chk("R7 swap from pin", reg_rdata, 32'h2000_0002);
        wr(32'h0000_0C00);
        chk("R7 clear blocked", reg_rdata, 32'h2000_0C02);
        rtc_reset(2'b01, 2'b00, 1'b0);
        chk("R7 rtc reset clears swap", reg_rdata, 32'h2000_0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule